// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block turns the match strobes of two alarm comparators into host-visible status flags and an active-low interrupt pin. A mode input picks one of two behaviours. In latched mode each alarm match raises its own sticky flag, and the interrupt pin is pulled low for as long as any raised flag has its enable bit set. In pulsed mode the enables have no effect. An alarm 0 match then produces a single self-timed low pulse on the pin, and alarm 1 only raises its flag, which the host must poll.

The host clears both flags by reading the status byte over a serial link. The block watches a read-in-progress level and the link's bit clock. The flags drop only at the falling edge of the eighth bit clock of that byte. A read that is abandoned early clears nothing. The pulse length is counted in ticks of the slow oscillator, which arrive as one-cycle strobes in the system clock domain. The comparators, the timekeeping counters and the serial protocol engine live outside this block. All inputs are synchronous to `clk`.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: During and after reset, both flags read 0 and `irq_n` reads 1, whatever the mode.
- R2: With `pulse_mode`=0, a `hit0` or `hit1` high at a clock edge makes `flag0` or `flag1` (respectively) read 1 after that edge.
- R3: With `pulse_mode`=0, `irq_n` is 0 exactly when (`flag0` and `irq_en0`) or (`flag1` and `irq_en1`) holds. A flag whose enable is 0 stays set but leaves `irq_n` at 1.
- R4: While `stat_rd`=1, a falling edge of `stat_bclk` is a 1-to-0 change between consecutive clock samples. Both flags clear at the 8th such edge (BYTE_BITS), and not at an earlier one. Later edges in the same read do nothing. With `stat_rd`=0 the edge count restarts from zero.
- R5: When the flags clear in latched mode, `irq_n` returns to 1 in the same cycle.
- R6: With `pulse_mode`=1, `irq_en0` and `irq_en1` are ignored and `hit0` never sets `flag0`. `hit1` still sets `flag1`, but `flag1` does not move `irq_n`.
- R7: With `pulse_mode`=1, a `hit0` drives `irq_n` to 0 from the next cycle until exactly PULSE_CYCLES (1024) `osc_tick` strobes have been counted after that edge.
- R8: A `hit0` that arrives during a running pulse restarts the count at PULSE_CYCLES, so the pin stays low for one longer pulse, not two.
- R9: A `hit0` or `hit1` at the same edge as the clearing bit-clock edge wins, and that flag stays set.
- R10: Setting `pulse_mode` to 0 cancels a running pulse. Returning to 1 does not resume it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_mode | input | 1 | 0 = latched mode, 1 = pulsed mode |
| hit0 | input | 1 | Alarm 0 match strobe |
| hit1 | input | 1 | Alarm 1 match strobe |
| irq_en0 | input | 1 | Alarm 0 interrupt enable (latched mode only) |
| irq_en1 | input | 1 | Alarm 1 interrupt enable (latched mode only) |
| stat_rd | input | 1 | Status byte read in progress |
| stat_bclk | input | 1 | Serial bit clock, sampled by clk |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| flag0 | output | 1 | Alarm 0 status flag |
| flag1 | output | 1 | Alarm 1 status flag |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
The bench goes after the read-clear boundary. It checks that the flags survive seven bit-clock falls, clear on the eighth, and ignore a ninth. A design that counts rising edges, or that clears at the start of the read, loses a flag early. An abandoned read followed by a fresh one must need a full eight falls again. A counter that is not restarted lets the flag drop too soon. The bench also measures the pulse in oscillator ticks, alone and with a retrigger partway through, where an off-by-one or an added second pulse shows up as the wrong total. It then fires a match on the clearing edge, and switches mode during a pulse. A wrong priority drops the flag, and a timer that is not cancelled leaves the pin stuck low.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int unsigned DEF_PULSE_CYCLES = 1024;
  localparam int unsigned DEF_BYTE_BITS    = 8;
  localparam int unsigned NUM_ALARMS       = 2;

  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_PULSE = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/alarm_rd_clear.sv
module alarm_rd_clear #(
  parameter int unsigned BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_active,
  input  logic bclk,
  output logic clr_o
);
  localparam int unsigned CW = $clog2(BYTE_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);

  logic          bclk_q;
  logic [CW-1:0] falls;
  logic          fall;

  assign fall  = bclk_q & ~bclk;
  assign clr_o = rd_active & fall & (falls == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      falls  <= '0;
    end else begin
      bclk_q <= bclk;
      if (!rd_active)
        falls <= '0;
      else if (fall && falls != FULL)
        falls <= falls + 1'b1;
    end
  end
endmodule

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flag_o[i] <= 1'b0;
      else if (set_i[i])
        flag_o[i] <= 1'b1;   // a match beats a same-edge clear
      else if (clr_i)
        flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_pulse_timer.sv
module alarm_pulse_timer #(
  parameter int unsigned LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic arm_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] remain;

  assign active_o = (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i)
      remain <= '0;
    else if (arm_i)
      remain <= LOAD;
    else if (tick_i && active_o)
      remain <= remain - 1'b1;
  end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = DEF_PULSE_CYCLES,
  parameter int unsigned BYTE_BITS    = DEF_BYTE_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic hit0,
  input  logic hit1,
  input  logic irq_en0,
  input  logic irq_en1,
  input  logic stat_rd,
  input  logic stat_bclk,
  input  logic osc_tick,
  output logic flag0,
  output logic flag1,
  output logic irq_n
);
  irq_mode_e               mode;
  logic                    rd_clr;
  logic                    pulse_on;
  logic [NUM_ALARMS-1:0]   set_vec;
  logic [NUM_ALARMS-1:0]   flags;
  logic [NUM_ALARMS-1:0]   en_vec;
  logic                    latch_req;

  assign mode    = irq_mode_e'(pulse_mode);
  assign set_vec = {hit1, hit0 & (mode == MODE_LATCH)};
  assign en_vec  = {irq_en1, irq_en0};

  alarm_rd_clear #(.BYTE_BITS(BYTE_BITS)) u_rdclr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_active (stat_rd),
    .bclk      (stat_bclk),
    .clr_o     (rd_clr)
  );

  alarm_flag_bank #(.N(NUM_ALARMS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (rd_clr),
    .flag_o (flags)
  );

  alarm_pulse_timer #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (mode == MODE_PULSE),
    .arm_i    (hit0),
    .tick_i   (osc_tick),
    .active_o (pulse_on)
  );

  assign latch_req = |(flags & en_vec);
  assign flag0     = flags[0];
  assign flag1     = flags[1];
  assign irq_n     = (mode == MODE_PULSE) ? ~pulse_on : ~latch_req;
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int unsigned PULSE_CYCLES = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic pulse_mode,
  input logic hit0,
  input logic hit1,
  input logic irq_en0,
  input logic irq_en1,
  input logic stat_rd,
  input logic osc_tick,
  input logic flag0,
  input logic flag1,
  input logic irq_n
);
  int unsigned low_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || !pulse_mode || irq_n || hit0)
      low_ticks <= 0;
    else if (osc_tick)
      low_ticks <= low_ticks + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!flag0 && !flag1 && irq_n));

  p_hit0_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && hit0) |=> flag0);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && !irq_en0 && !irq_en1) |-> irq_n);

  p_fall_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag0) || $fell(flag1)) |-> $past(stat_rd));

  p_pulse_no_flag0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && hit0 && !flag0) |=> !flag0);

  p_pulse_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && hit0) ##1 pulse_mode |-> !irq_n);

  p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_ticks <= PULSE_CYCLES);

  p_hit1_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> flag1);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pulse_mode (pulse_mode),
  .hit0       (hit0),
  .hit1       (hit1),
  .irq_en0    (irq_en0),
  .irq_en1    (irq_en1),
  .stat_rd    (stat_rd),
  .osc_tick   (osc_tick),
  .flag0      (flag0),
  .flag1      (flag1),
  .irq_n      (irq_n)
);

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
  localparam int PULSE = 1024;
  localparam int BITS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_mode = 0, hit0 = 0, hit1 = 0, irq_en0 = 0, irq_en1 = 0;
  logic stat_rd = 0, stat_bclk = 0, osc_tick = 0;
  logic flag0, flag1, irq_n;

  always #10 clk = ~clk;

  alarm_irq_ctrl u_alarm_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .hit0(hit0), .hit1(hit1),
    .irq_en0(irq_en0), .irq_en1(irq_en1), .stat_rd(stat_rd), .stat_bclk(stat_bclk),
    .osc_tick(osc_tick), .flag0(flag0), .flag1(flag1), .irq_n(irq_n)
  );

  int vectors = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_f0, m_f1, m_prev;
  int m_falls, m_left;

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    bit fall, clr, n0, n1;
    int nfalls, nleft, exp_irq;
    fall   = m_prev && !stat_bclk;
    clr    = stat_rd && fall && (m_falls == BITS - 1);
    n0     = (!pulse_mode && hit0) ? 1'b1 : (clr ? 1'b0 : m_f0);
    n1     = hit1 ? 1'b1 : (clr ? 1'b0 : m_f1);
    nfalls = !stat_rd ? 0 : ((fall && m_falls < BITS) ? m_falls + 1 : m_falls);
    if (!pulse_mode)                   nleft = 0;
    else if (hit0)                     nleft = PULSE;
    else if (osc_tick && m_left > 0)   nleft = m_left - 1;
    else                               nleft = m_left;
    @(posedge clk);
    #2;
    if (!rst_n) begin
      m_f0 = 0; m_f1 = 0; m_prev = 0; m_falls = 0; m_left = 0;
    end else begin
      m_f0 = n0; m_f1 = n1; m_prev = stat_bclk; m_falls = nfalls; m_left = nleft;
    end
    exp_irq = pulse_mode ? int'(m_left == 0)
                         : int'(!((m_f0 && irq_en0) || (m_f1 && irq_en1)));
    check({flag0, flag1, irq_n} == {m_f0, m_f1, 1'(exp_irq)}, cur_req,
          int'({flag0, flag1, irq_n}), int'({m_f0, m_f1, 1'(exp_irq)}));
  endtask

  task automatic bit_falls(int n);
    for (int i = 0; i < n; i++) begin
      stat_bclk = 1; step();
      stat_bclk = 0; step();
    end
  endtask

  task automatic pulse_hit();
    hit0 = 1; step(); hit0 = 0;
  endtask

  // applies ticks until the pin returns high; returns the tick count
  task automatic ticks_to_idle(output int n);
    n = 0;
    while (irq_n == 0 && n < 4 * PULSE) begin
      osc_tick = 1; step(); n++;
      osc_tick = 0; step();
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int n;
    // R1 reset
    cur_req = "R1";
    repeat (3) step();
    check(flag0 == 0 && flag1 == 0 && irq_n == 1, "R1", int'({flag0, flag1, irq_n}), 1);
    rst_n = 1; step();

    // R2/R3 latched mode
    cur_req = "R2";
    irq_en0 = 1;
    hit0 = 1; step(); hit0 = 0;
    check(flag0 == 1, "R2", flag0, 1);
    check(irq_n == 0, "R3", irq_n, 0);
    hit1 = 1; step(); hit1 = 0;
    check(flag1 == 1, "R2", flag1, 1);
    cur_req = "R3";
    irq_en0 = 0; step();
    check(irq_n == 1 && flag0 == 1, "R3", int'({flag0, irq_n}), 3);

    // R4/R5 read clear at 8th fall
    cur_req = "R4";
    irq_en0 = 1; irq_en1 = 1;
    stat_rd = 1;
    bit_falls(BITS - 1);
    check(flag0 == 1 && flag1 == 1, "R4", int'({flag0, flag1}), 3);
    bit_falls(1);
    check(flag0 == 0 && flag1 == 0, "R4", int'({flag0, flag1}), 0);
    check(irq_n == 1, "R5", irq_n, 1);
    hit1 = 1; step(); hit1 = 0;
    bit_falls(3);
    check(flag1 == 1, "R4", flag1, 1);
    stat_rd = 0; step();

    // R4 abandoned read restarts count
    stat_rd = 1; bit_falls(5);
    stat_rd = 0; step();
    stat_rd = 1; bit_falls(5);
    check(flag1 == 1, "R4", flag1, 1);
    bit_falls(3);
    check(flag1 == 0, "R4", flag1, 0);
    stat_rd = 0; step();

    // R9 match on the clearing edge
    cur_req = "R9";
    hit0 = 1; step(); hit0 = 0;
    stat_rd = 1; bit_falls(BITS - 1);
    stat_bclk = 1; step();
    stat_bclk = 0; hit1 = 1; step(); hit1 = 0;
    check(flag1 == 1 && flag0 == 0, "R9", int'({flag0, flag1}), 1);
    stat_rd = 0; step();

    // R6 pulsed mode ignores enables and flag1
    cur_req = "R6";
    pulse_mode = 1; step();
    check(irq_n == 1, "R6", irq_n, 1);
    stat_rd = 1; bit_falls(BITS); stat_rd = 0; step();
    hit1 = 1; step(); hit1 = 0;
    check(flag1 == 1 && irq_n == 1, "R6", int'({flag1, irq_n}), 3);

    // R7 pulse length
    cur_req = "R7";
    pulse_hit();
    check(flag0 == 0, "R6", flag0, 0);
    check(irq_n == 0, "R7", irq_n, 0);
    ticks_to_idle(n);
    check(n == PULSE, "R7", n, PULSE);

    // R8 retrigger
    cur_req = "R8";
    pulse_hit();
    for (int i = 0; i < 300; i++) begin
      osc_tick = 1; step(); osc_tick = 0; step();
    end
    pulse_hit();
    ticks_to_idle(n);
    check(n + 300 == PULSE + 300, "R8", n + 300, PULSE + 300);

    // R10 leaving pulsed mode cancels
    cur_req = "R10";
    irq_en0 = 0; irq_en1 = 0;
    pulse_hit();
    for (int i = 0; i < 10; i++) begin
      osc_tick = 1; step(); osc_tick = 0; step();
    end
    pulse_mode = 0; step();
    check(irq_n == 1, "R10", irq_n, 1);
    pulse_mode = 1; step(); step();
    check(irq_n == 1, "R10", irq_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule